// File: doc/BRIEF.md
# Oscillator Fail Detector and Switcher

This block watches an external oscillator from the internal clock domain and chooses which of the two oscillators drives the system. The external clock is never used as a clock inside the block. It passes through a two-flop synchronizer, and an edge detector turns each transition into a one-cycle pulse. If no pulse arrives for 16 consecutive internal-clock cycles, the block declares a failure, raises a status flag and selects the internal oscillator, which runs at a nominal 4 MHz (250 ns period). Recovery needs 64 consecutive 16-cycle observation windows, each holding at least one external edge. The block then clears the flag and returns to the external source. The hysteresis stops it from chattering between sources.

Two configuration bits control the block. One enables fail switching; while it is clear, the flag never rises. The other forces the internal oscillator no matter what the external input does. In that mode the monitor pin carries the internal clock divided by four. Clock selection is a registered select signal that a glitch-free clock multiplexer elsewhere would consume.

Top module: `osc_fail_switch`

## Requirements
- R1: While reset is asserted with the force bit (bit 4 of `cfg_word`) clear, `sel_int`, `fail_flag` and `mon_out` are all 0, and they stay 0 afterwards while the external clock toggles.
- R2: With the fail-enable bit (bit 3 of `cfg_word`) set, `fail_flag` rises after 16 consecutive internal-clock cycles without a synchronized external edge, and never earlier.
- R3: An external clock that keeps toggling never raises `fail_flag`.
- R4: Once failed, `fail_flag` falls only after 64 consecutive 16-cycle windows each containing at least one external edge.
- R5: A 16-cycle window without an external edge during recovery restarts the count of good windows from zero.
- R6: While bit 3 of `cfg_word` is 0, `fail_flag` is 0 from the next cycle on, and no failure is declared however long the external clock stays silent.
- R7: While bit 4 of `cfg_word` is 1, `sel_int` is 1 from the next cycle on, whatever the state of the external clock.
- R8: While bit 4 is 1, `mon_out` is the internal clock divided by 4 (two cycles high, two low). While bit 4 is 0, `mon_out` is 0 from the next cycle on.
- R9: `fail_flag` reports a detected failure whether or not bit 4 is set, and it reads 0 when the internal clock is selected only because of bit 4.
- R10: `sel_int` is registered: in each cycle it equals the OR of the force bit and `fail_flag` from the cycle before (1 = internal source, 0 = external source).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| int_clk | input | 1 | Internal oscillator clock that runs all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External oscillator, sampled as data |
| cfg_word | input | 8 | Configuration; bit 3 fail-switch enable, bit 4 force internal |
| sel_int | output | 1 | Registered clock select, 1 = internal oscillator |
| fail_flag | output | 1 | External oscillator is judged failed |
| mon_out | output | 1 | Internal clock divided by 4 while forced, else low |

## Verification
Failure detection and the forced-internal mode can act on the select in the same cycle, so both are driven together. The force bit is set while the external clock runs, which shows `sel_int` high with `fail_flag` low. The external clock is then stopped under force; the flag has to rise while the select stays high. The force bit is released while the failure still holds, and the select has to stay internal. Recovery is then allowed with force off, and the select has to return to external only when the flag clears.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int CFG_W       = 8;
  localparam int FAIL_EN_BIT = 3;
  localparam int FORCE_BIT   = 4;

  typedef enum logic {SRC_EXT = 1'b0, SRC_INT = 1'b1} src_e;

  // Source choice from the force request and the failure state.
  function automatic src_e pick_source(logic force_int, logic failed);
    return (force_int || failed) ? SRC_INT : SRC_EXT;
  endfunction

  // A window counts as good when an edge was seen earlier or arrives now.
  function automatic logic window_good(logic seen, logic edge_now);
    return seen | edge_now;
  endfunction
endpackage

// File: rtl/ofs_edge_sync.sv
module ofs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_pulse
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], async_in};
  end

  assign edge_pulse = shreg[STAGES] ^ shreg[STAGES-1];
endmodule

// File: rtl/ofs_fail_mon.sv
module ofs_fail_mon #(
  parameter int SIL_LIM  = 16,
  parameter int WIN_LEN  = 16,
  parameter int REC_WINS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic edge_pulse,
  output logic failed,
  output logic quiet_hit,
  output logic rec_done
);
  import ofs_pkg::*;
  localparam int QW = $clog2(SIL_LIM);
  localparam int WW = $clog2(WIN_LEN);
  localparam int GW = $clog2(REC_WINS);

  logic [QW-1:0] quiet_cnt;
  logic [WW-1:0] win_pos;
  logic          win_seen;
  logic [GW-1:0] good_cnt;
  logic          win_end;
  logic          win_ok;

  assign win_end   = (win_pos == WW'(WIN_LEN - 1));
  assign win_ok    = window_good(win_seen, edge_pulse);
  assign quiet_hit = !failed && !edge_pulse && (quiet_cnt == QW'(SIL_LIM - 1));
  assign rec_done  = failed && win_end && win_ok && (good_cnt == GW'(REC_WINS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failed    <= 1'b0;
      quiet_cnt <= '0;
      win_pos   <= '0;
      win_seen  <= 1'b0;
      good_cnt  <= '0;
    end else if (!enable) begin
      failed    <= 1'b0;
      quiet_cnt <= '0;
      win_pos   <= '0;
      win_seen  <= 1'b0;
      good_cnt  <= '0;
    end else if (!failed) begin
      win_pos  <= '0;
      win_seen <= 1'b0;
      good_cnt <= '0;
      if (edge_pulse) begin
        quiet_cnt <= '0;
      end else if (quiet_hit) begin
        quiet_cnt <= '0;
        failed    <= 1'b1;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end else begin
      quiet_cnt <= '0;
      if (win_end) begin
        win_pos  <= '0;
        win_seen <= 1'b0;
        if (rec_done) begin
          failed   <= 1'b0;
          good_cnt <= '0;
        end else if (win_ok) begin
          good_cnt <= good_cnt + 1'b1;
        end else begin
          good_cnt <= '0;
        end
      end else begin
        win_pos  <= win_pos + 1'b1;
        win_seen <= win_ok;
      end
    end
  end
endmodule

// File: rtl/ofs_div_mon.sv
module ofs_div_mon #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mon
);
  localparam int DW = $clog2(DIV);
  logic [DW-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_cnt <= '0;
    else if (run) div_cnt <= div_cnt + 1'b1;
    else          div_cnt <= '0;
  end

  assign mon = div_cnt[DW-1];
endmodule

// File: rtl/osc_fail_switch.sv
module osc_fail_switch #(
  parameter int SIL_LIM     = 16,
  parameter int WIN_LEN     = 16,
  parameter int REC_WINS    = 64,
  parameter int MON_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      int_clk,
  input  logic                      rst_n,
  input  logic                      ext_clk,
  input  logic [ofs_pkg::CFG_W-1:0] cfg_word,
  output logic                      sel_int,
  output logic                      fail_flag,
  output logic                      mon_out
);
  import ofs_pkg::*;

  logic edge_pulse;
  logic quiet_hit;
  logic rec_done;
  logic fail_en;
  logic force_int;
  src_e src_q;

  assign fail_en   = cfg_word[FAIL_EN_BIT];
  assign force_int = cfg_word[FORCE_BIT];

  ofs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(int_clk), .rst_n(rst_n), .async_in(ext_clk), .edge_pulse(edge_pulse)
  );

  ofs_fail_mon #(.SIL_LIM(SIL_LIM), .WIN_LEN(WIN_LEN), .REC_WINS(REC_WINS)) u_mon (
    .clk(int_clk), .rst_n(rst_n), .enable(fail_en), .edge_pulse(edge_pulse),
    .failed(fail_flag), .quiet_hit(quiet_hit), .rec_done(rec_done)
  );

  ofs_div_mon #(.DIV(MON_DIV)) u_div (
    .clk(int_clk), .rst_n(rst_n), .run(force_int), .mon(mon_out)
  );

  always_ff @(posedge int_clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_EXT;
    else        src_q <= pick_source(force_int, fail_flag);
  end

  assign sel_int = (src_q == SRC_INT);
endmodule

// File: rtl/ofs_chk.sv
module ofs_chk #(
  parameter int SIL_LIM = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_word,
  input logic       edge_pulse,
  input logic       rec_done,
  input logic       sel_int,
  input logic       fail_flag,
  input logic       mon_out
);
  localparam int CW = $clog2(SIL_LIM) + 1;
  logic [CW-1:0] calm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     calm <= '0;
    else if (edge_pulse)            calm <= '0;
    else if (calm != CW'(SIL_LIM))  calm <= calm + 1'b1;
  end

  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_flag) |-> (calm >= CW'(SIL_LIM)));

  // R4
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_flag) |-> ($past(rec_done) || !$past(cfg_word[3])));

  // R6
  flag_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[3] |=> !fail_flag);

  // R7
  force_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_word[4] |=> sel_int);

  // R8
  mon_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[4] |=> !mon_out);

  // R10
  sel_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sel_int == $past(cfg_word[4] | fail_flag)));
endmodule

bind osc_fail_switch ofs_chk #(.SIL_LIM(SIL_LIM)) u_chk (
  .clk(int_clk), .rst_n(rst_n), .cfg_word(cfg_word), .edge_pulse(edge_pulse),
  .rec_done(rec_done), .sel_int(sel_int), .fail_flag(fail_flag), .mon_out(mon_out)
);

// File: tb/osc_fail_switch_tb.sv
`timescale 1ns/1ps
module osc_fail_switch_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext = 1'b0;
  logic       ext_run = 1'b0;
  logic [7:0] cfg = 8'h08;
  logic       sel_int, fail_flag, mon_out;
  int         checks = 0;
  int         errors = 0;

  localparam int WIN = 16;

  always #2 clk = ~clk;

  initial forever begin
    #7;
    if (ext_run) ext = ~ext;
  end

  osc_fail_switch u_dut (
    .int_clk(clk), .rst_n(rst_n), .ext_clk(ext), .cfg_word(cfg),
    .sel_int(sel_int), .fail_flag(fail_flag), .mon_out(mon_out)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1", "sel in reset", sel_int, 1'b0);
    chk("R1", "flag in reset", fail_flag, 1'b0);
    chk("R1", "mon in reset", mon_out, 1'b0);
    ext_run = 1'b1;
    rst_n = 1'b1;
    cyc(5);
    chk("R1", "sel after reset", sel_int, 1'b0);
  endtask

  task automatic t_running();
    logic seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      cyc(1);
      if (fail_flag || sel_int) seen = 1'b1;
    end
    chk("R3", "no fail while toggling", seen, 1'b0);
  endtask

  task automatic t_fail();
    int n = 0;
    ext_run = 1'b0;
    cyc(12);
    chk("R2", "no flag before 16 quiet cycles", fail_flag, 1'b0);
    n = 12;
    while (!fail_flag && n < 40) begin cyc(1); n++; end
    chk("R2", "flag within window", (n >= 16 && n <= 20), 1'b1);
    chk("R10", "select lags flag by one", sel_int, 1'b0);
    cyc(1);
    chk("R10", "select internal after flag", sel_int, 1'b1);
  endtask

  task automatic wait_recover(int max_cyc);
    int n = 0;
    while (fail_flag && n < max_cyc) begin cyc(1); n++; end
  endtask

  task automatic t_recover();
    ext_run = 1'b1;
    cyc(60 * WIN);
    chk("R4", "still failed after 60 windows", fail_flag, 1'b1);
    wait_recover(8 * WIN);
    chk("R4", "recovered by 68 windows", fail_flag, 1'b0);
    cyc(1);
    chk("R4", "select back to external", sel_int, 1'b0);
  endtask

  task automatic t_break();
    ext_run = 1'b0;
    cyc(30);
    chk("R5", "failed again", fail_flag, 1'b1);
    ext_run = 1'b1;
    cyc(40 * WIN);
    ext_run = 1'b0;
    cyc(48);
    ext_run = 1'b1;
    cyc(60 * WIN);
    chk("R5", "gap restarted window count", fail_flag, 1'b1);
    wait_recover(8 * WIN);
    chk("R5", "recovered after fresh run", fail_flag, 1'b0);
    cyc(2);
  endtask

  task automatic t_disable();
    cfg[3] = 1'b0;
    ext_run = 1'b0;
    cyc(100);
    chk("R6", "no flag while disabled", fail_flag, 1'b0);
    chk("R6", "no switch while disabled", sel_int, 1'b0);
    cfg[3] = 1'b1;
    cyc(30);
    chk("R6", "flag once re-enabled", fail_flag, 1'b1);
    cfg[3] = 1'b0;
    cyc(1);
    chk("R6", "flag clears on disable", fail_flag, 1'b0);
    cyc(1);
    chk("R6", "select external on disable", sel_int, 1'b0);
    ext_run = 1'b1;
    cyc(10);
    cfg[3] = 1'b1;
    cyc(10);
  endtask

  task automatic t_force();
    logic m [16];
    int   highs = 0;
    logic pat_ok = 1'b1;
    cfg[4] = 1'b1;
    cyc(2);
    chk("R7", "forced select", sel_int, 1'b1);
    chk("R9", "flag low when only forced", fail_flag, 1'b0);
    for (int i = 0; i < 16; i++) begin
      cyc(1);
      m[i] = mon_out;
      if (mon_out) highs++;
    end
    for (int i = 0; i < 14; i++) if (m[i] == m[i+2]) pat_ok = 1'b0;
    chk("R8", "divide-by-4 duty", (highs == 8), 1'b1);
    chk("R8", "divide-by-4 period", pat_ok, 1'b1);
    ext_run = 1'b0;
    cyc(30);
    chk("R9", "flag reports fail under force", fail_flag, 1'b1);
    chk("R7", "select held under force and fail", sel_int, 1'b1);
    cfg[4] = 1'b0;
    cyc(2);
    chk("R10", "select stays internal while failed", sel_int, 1'b1);
    chk("R8", "monitor low when not forced", mon_out, 1'b0);
    ext_run = 1'b1;
    wait_recover(70 * WIN);
    chk("R4", "recovered after forced phase", fail_flag, 1'b0);
    cyc(1);
    chk("R10", "select external after recovery", sel_int, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_running();
    t_fail();
    t_recover();
    t_break();
    t_disable();
    t_force();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule